// File: doc/BRIEF.md
# Backplane Reset and Override Control Register

This block is a byte-wide control register on a simple memory-mapped write/read port. It controls two open-drain backplane lines: the shared maskable-reset line and the non-volatile-memory read-only (NVMRO) line. It can also turn an incoming maskable-reset level into a local reset request. Each open-drain line is modelled as separate terms: an output level tied low and a drive enable. For the maskable-reset line there is also a received level. The physical buffers and the reset controller are outside the block.

The register answers at byte address 0x6C1. It has three writable bits. Bit 4 is the reset mask: when it is 1, a low level on the incoming maskable-reset line raises a local reset request. Bit 3 pulls the maskable-reset line low. Bit 2 pulls the NVMRO line low.

Bit 2 may only be set while the system-controller strap is low. A small state machine owns bit 2, with the states NV_RELEASED and NV_DRIVING:
- It goes from NV_RELEASED to NV_DRIVING on a write of 1 to bit 2 while the strap is low.
- It goes from NV_DRIVING back to NV_RELEASED on a write of 0 to bit 2, or as soon as the strap is high.

A second state machine issues the reset request, with the states RQ_IDLE and RQ_ACTIVE:
- It goes from RQ_IDLE to RQ_ACTIVE when the mask is set and the synchronised line is low.
- It returns to RQ_IDLE when either of those conditions ends.

Top module: `backplane_ctl_reg`

## Requirements
- R1: After the board-level reset (rst_n low), every writable bit reads 0, both drive enables are 0 and local_rst_req is 0.
- R2: A read at address 0x6C1 returns the mask in bit 4, the reset-drive bit in bit 3 and the NVMRO override in bit 2. A read at any other address returns 0, and a write at any other address changes nothing.
- R3: With bit 3 set, mrst_oe is 1 and mrst_out is 0. With bit 3 clear, mrst_oe is 0.
- R4: A write with bit 2 set while syscon_n is 0 sets bit 2 and drives nvmro_oe high, with nvmro_out at 0. A write with bit 2 clear releases it.
- R5: A write that sets bit 2 while syscon_n is 1 leaves bit 2 at 0. Bits 3 and 4 are still taken from that same write.
- R6: If syscon_n goes high while bit 2 is set, bit 2 reads 0 and nvmro_oe is 0 after the next rising clock edge.
- R7: With the mask set, local_rst_req rises after the third rising edge at which mrst_in is sampled low (two synchroniser stages plus the state register). It stays high for as long as the synchronised line stays low.
- R8: With the mask clear, a low level on mrst_in never raises local_rst_req.
- R9: While a request is active, the register bits keep their values. Clearing the mask by a write drops local_rst_req after the rising edge that follows the write.
- R10: Bits 7 to 5 and 1 to 0 read as 0 whatever value was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Board-level reset, active low, asynchronous |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| syscon_n | input | 1 | System-controller strap, low when this board is system controller |
| mrst_in | input | 1 | Received level of the backplane maskable-reset line |
| mrst_oe | output | 1 | Drive enable for the maskable-reset line |
| mrst_out | output | 1 | Driven level of the maskable-reset line, always 0 |
| nvmro_oe | output | 1 | Drive enable for the NVMRO line |
| nvmro_out | output | 1 | Driven level of the NVMRO line, always 0 |
| local_rst_req | output | 1 | Local reset request |

## Verification
The hardest state to reach from the ports is the strap rising while the NVMRO override is set and driving. No write can produce that state: a write of bit 2 only takes effect while the strap is low. The bench therefore first sets bit 2 with the strap low, then raises the strap between writes, and checks both the drive enable and the readback on the next edge. The reset-request latency is swept over a range of low-pulse lengths with the mask both set and clear, and the expected request waveform is computed from the pulse length.

// File: rtl/bprc_pkg.sv
package bprc_pkg;
    localparam int DATA_W   = 8;
    localparam int BIT_MASK = 4;
    localparam int BIT_MROUT = 3;
    localparam int BIT_NVRO = 2;

    typedef enum logic {
        NV_RELEASED = 1'b0,
        NV_DRIVING  = 1'b1
    } nv_state_t;

    typedef enum logic {
        RQ_IDLE   = 1'b0,
        RQ_ACTIVE = 1'b1
    } rq_state_t;
endpackage

// File: rtl/bprc_sync.sv
module bprc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/bprc_nvmro_fsm.sv
module bprc_nvmro_fsm
    import bprc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic strap_high,
    output logic drive
);
    nv_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NV_RELEASED: if (wr_hit && wr_bit && !strap_high) state_d = NV_DRIVING;
            NV_DRIVING:  if (strap_high || (wr_hit && !wr_bit)) state_d = NV_RELEASED;
            default:     state_d = NV_RELEASED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NV_RELEASED;
        else        state_q <= state_d;
    end

    always_comb begin
        drive = (state_q == NV_DRIVING);
    end
endmodule

// File: rtl/bprc_reset_fsm.sv
module bprc_reset_fsm
    import bprc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mask,
    input  logic line_low,
    output logic req
);
    rq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE:   if (mask && line_low) state_d = RQ_ACTIVE;
            RQ_ACTIVE: if (!(mask && line_low)) state_d = RQ_IDLE;
            default:   state_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req = (state_q == RQ_ACTIVE);
    end
endmodule

// File: rtl/backplane_ctl_reg.sv
module backplane_ctl_reg
    import bprc_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 12'h6C1,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              syscon_n,
    input  logic              mrst_in,
    output logic              mrst_oe,
    output logic              mrst_out,
    output logic              nvmro_oe,
    output logic              nvmro_out,
    output logic              local_rst_req
);
    logic hit;
    logic wr_hit;
    logic mask_q;
    logic mrout_q;
    logic nvro_drive;
    logic line_sync;

    assign hit    = (bus_addr == REG_ADDR);
    assign wr_hit = bus_wr && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= 1'b0;
            mrout_q <= 1'b0;
        end else if (wr_hit) begin
            mask_q  <= bus_wdata[BIT_MASK];
            mrout_q <= bus_wdata[BIT_MROUT];
        end
    end

    bprc_nvmro_fsm u_nvmro (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .wr_bit     (bus_wdata[BIT_NVRO]),
        .strap_high (syscon_n),
        .drive      (nvro_drive)
    );

    bprc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (mrst_in),
        .q_out (line_sync)
    );

    bprc_reset_fsm u_rq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask     (mask_q),
        .line_low (!line_sync),
        .req      (local_rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[BIT_MASK]  = mask_q;
            bus_rdata[BIT_MROUT] = mrout_q;
            bus_rdata[BIT_NVRO]  = nvro_drive;
        end
    end

    assign mrst_oe   = mrout_q;
    assign mrst_out  = 1'b0;
    assign nvmro_oe  = nvro_drive;
    assign nvmro_out = 1'b0;
endmodule

// File: rtl/bprc_checker.sv
module bprc_checker #(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h6C1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              syscon_n,
    input logic              mrst_oe,
    input logic              nvmro_oe,
    input logic              local_rst_req,
    input logic              mask_q
);
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[7:5] == 3'b000) && (bus_rdata[1:0] == 2'b00));

    assert_strap_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(syscon_n) |-> !nvmro_oe);

    assert_gated_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ADDR && syscon_n && bus_wdata[2]) |=> !nvmro_oe);

    assert_mrout_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ADDR) |=> (mrst_oe == $past(bus_wdata[3])));

    assert_req_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst_req |-> $past(mask_q));
endmodule

bind backplane_ctl_reg bprc_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_bprc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .syscon_n      (syscon_n),
    .mrst_oe       (mrst_oe),
    .nvmro_oe      (nvmro_oe),
    .local_rst_req (local_rst_req),
    .mask_q        (mask_q)
);

// File: tb/test_backplane_ctl_reg.sv
`timescale 1ns/1ps
module test_backplane_ctl_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] RA = 12'h6C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = RA;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        syscon_n = 1'b0;
    logic        mrst_in = 1'b1;
    logic        mrst_oe, mrst_out, nvmro_oe, nvmro_out, local_rst_req;

    int checks = 0;
    int fails  = 0;

    backplane_ctl_reg i_backplane_ctl_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .syscon_n(syscon_n),
        .mrst_in(mrst_in), .mrst_oe(mrst_oe), .mrst_out(mrst_out),
        .nvmro_oe(nvmro_oe), .nvmro_out(nvmro_out), .local_rst_req(local_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = RA;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 oe", {6'b0, mrst_oe, nvmro_oe}, 8'h00);
        check("R1 req", {7'b0, local_rst_req}, 8'h00);
        rst_n = 1'b1;

        // Sweep of every write value with both strap levels: R2 R3 R4 R5 R10
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] exp;
                write_reg(RA, 8'h00);
                @(negedge clk);
                syscon_n = s[0];
                write_reg(RA, v[7:0]);
                exp = (v[7:0] & 8'h18) | ((s == 0) ? (v[7:0] & 8'h04) : 8'h00);
                check(s == 0 ? "R2/R4/R10 readback" : "R5/R10 readback", bus_rdata, exp);
                check("R3 mrst_oe", {7'b0, mrst_oe}, {7'b0, exp[3]});
                check(s == 0 ? "R4 nvmro_oe" : "R5 nvmro_oe", {7'b0, nvmro_oe}, {7'b0, exp[2]});
                check("R3/R4 driven levels", {6'b0, mrst_out, nvmro_out}, 8'h00);
            end
        end

        // R4 release by write
        syscon_n = 1'b0;
        write_reg(RA, 8'h04);
        write_reg(RA, 8'h00);
        check("R4 release", {7'b0, nvmro_oe}, 8'h00);

        // R2: other addresses read 0 and writes there are ignored
        write_reg(RA, 8'h1C);
        write_reg(12'h6C0, 8'h00);
        check("R2 foreign write", bus_rdata, 8'h1C);
        bus_addr = 12'h6C2; #1;
        check("R2 foreign read", bus_rdata, 8'h00);
        bus_addr = RA; #1;

        // R6: strap rises while driving
        @(negedge clk);
        syscon_n = 1'b1;
        @(negedge clk); #1;
        check("R6 nvmro_oe", {7'b0, nvmro_oe}, 8'h00);
        check("R6 readback", bus_rdata, 8'h18);
        syscon_n = 1'b0;
        write_reg(RA, 8'h00);

        // R7 R8: pulse-length sweep with the mask both ways
        for (int m = 0; m < 2; m++) begin
            for (int d = 1; d <= 6; d++) begin
                write_reg(RA, m[0] ? 8'h10 : 8'h00);
                @(negedge clk);
                mrst_in = 1'b0;
                for (int t = 1; t <= d + 4; t++) begin
                    logic e;
                    @(negedge clk); #1;
                    e = m[0] && (t >= 3) && (t <= d + 2);
                    check(m[0] ? "R7 request" : "R8 masked", {7'b0, local_rst_req}, {7'b0, e});
                    if (t == d) mrst_in = 1'b1;
                end
            end
        end

        // R9: request keeps register, clearing mask drops request
        write_reg(RA, 8'h18);
        @(negedge clk);
        mrst_in = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check("R9 request up", {7'b0, local_rst_req}, 8'h01);
        check("R9 register kept", bus_rdata, 8'h18);
        write_reg(RA, 8'h08);
        check("R9 still up at write", {7'b0, local_rst_req}, 8'h01);
        @(negedge clk); #1;
        check("R9 dropped", {7'b0, local_rst_req}, 8'h00);
        check("R9 readback", bus_rdata, 8'h08);
        mrst_in = 1'b1;

        // R1 again: reset mid-operation clears everything
        write_reg(RA, 8'h1C);
        rst_n = 1'b0; #1;
        check("R1 re-reset", bus_rdata, 8'h00);
        check("R1 re-reset oe", {6'b0, mrst_oe, nvmro_oe}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule